// File: doc/BRIEF.md
# Color Expansion Write Unit

This unit turns one host-written byte into eight pixels in display memory. Each bit of the byte picks a color for one pixel. A set bit gives the foreground color. A clear bit gives the background color in opaque mode, and in transparent mode it leaves the pixel untouched. A per-pixel enable mask can stop any pixel from being written. Two pixel layouts are supported: one byte per pixel, or two bytes per pixel where the upper byte comes from separate high color values.

The unit is started with a one-cycle strobe. The strobe carries the base address, the source byte, the mode, the layout, the four color bytes and the mask. All of these are captured at the strobe. The unit then steps through a fixed schedule and drives a byte-wide memory write port with at most one write per clock. It stays busy until the schedule is finished and then pulses done. The schedule is 8 steps in the one-byte layout and 16 steps in the two-byte layout.

Top module: `colexp_write_unit`

## Requirements
- R1: One operation covers exactly eight pixels. Source bit 7 maps to pixel 0, which sits at the base address, and bit 0 maps to pixel 7. Writes come out in rising address order, and every write address lies between the base and base plus 15.
- R2: A pixel whose source bit is 1 and whose mask bit is 1 is written with the foreground color (low byte `fg_lo_i`; in the two-byte layout also the high byte `fg_hi_i`).
- R3: When `opaque_i`=1, a pixel whose source bit is 0 and whose mask bit is 1 is written with the background color (`bg_lo_i`, and `bg_hi_i` in the two-byte layout).
- R4: When `opaque_i`=0, a pixel whose source bit is 0 gets no write, and its memory bytes keep their earlier contents.
- R5: Mask bit 7-p enables pixel p, the same position as the source bit. A pixel with a clear mask bit is never written, whatever its source bit.
- R6: When `wide_i`=0, pixel p takes one byte at address base+p.
- R7: When `wide_i`=1, pixel p takes two bytes. The low color byte goes to base+2p and is issued one cycle before the high byte at base+2p+1.
- R8: `busy_o` goes high in the cycle after an accepted `start_i` and stays high until `done_o` pulses for exactly one cycle, at which point `busy_o` is low. Every memory write happens while `busy_o` is high. A `start_i` that arrives while an operation is running is ignored.
- R9: Base address, source byte, mask, mode, layout and colors are sampled at the accepted strobe. Changes to them during the operation have no effect.
- R10: `done_o` goes high exactly 9 clock edges after the accepting edge in the one-byte layout, and 17 in the two-byte layout, whatever the mask and source values. This holds even when no pixel is enabled, in which case no write is issued.
- R11: After synchronous reset, `busy_o`, `done_o` and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted when idle |
| base_addr_i | input | ADDR_W | Address of pixel 0 |
| src_byte_i | input | 8 | Source bits, MSB first |
| mask_i | input | 8 | Per-pixel write enable, bit 7 = pixel 0 |
| opaque_i | input | 1 | 1: clear bits write background; 0: clear bits skipped |
| wide_i | input | 1 | 1: two bytes per pixel; 0: one byte per pixel |
| fg_lo_i | input | 8 | Foreground color, low byte |
| fg_hi_i | input | 8 | Foreground color, high byte |
| bg_lo_i | input | 8 | Background color, low byte |
| bg_hi_i | input | 8 | Background color, high byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_we_o | output | 1 | Byte write enable |
| mem_addr_o | output | ADDR_W | Byte write address |
| mem_wdata_o | output | 8 | Byte write data |

## Verification
The assertions check protocol properties on every cycle:
- writes happen only while busy;
- done lasts one cycle and is never raised together with busy or a write;
- busy rises only after a start strobe;
- every write address stays inside the 16-byte window above the captured base;
- the done state is reached only from the stepping state.

Only the bench scenarios can show the data results: which pixels take foreground or background color, which are skipped in transparent mode or by the mask, the high-byte placement in the two-byte layout, and the exact completion latency. The bench checks these against a memory model that is pre-filled with a known pattern. It also scrambles every input right after the strobe and re-strobes during a run, to show that operands are held and late strobes are ignored.

// File: rtl/colexp_pkg.sv
package colexp_pkg;
  localparam int PIX_N = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} colexp_st_e;

  typedef struct packed {
    logic [7:0] src;
    logic [7:0] mask;
    logic [7:0] fg_lo;
    logic [7:0] fg_hi;
    logic [7:0] bg_lo;
    logic [7:0] bg_hi;
    logic       opaque;
    logic       wide;
  } colexp_job_t;
endpackage

// File: rtl/colexp_ctrl.sv
module colexp_ctrl
  import colexp_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              wide_i,
  output logic              accept_o,
  output logic              run_o,
  output logic              fin_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST_NARROW = STEP_W'(PIX_N - 1);
  localparam logic [STEP_W-1:0] LAST_WIDE   = STEP_W'(2 * PIX_N - 1);

  colexp_st_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_step;

  assign last_step = wide_i ? LAST_WIDE : LAST_NARROW;
  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign run_o     = (state_q == ST_RUN);
  assign fin_o     = (state_q == ST_FIN);
  assign step_o    = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          step_q <= '0;
          if (start_i) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (step_q == last_step) state_q <= ST_FIN;
          else step_q <= step_q + 1'b1;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: completion is entered only from the stepping state
  assert_fin_from_run_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIN) |-> ($past(state_q) == ST_RUN));
endmodule

// File: rtl/colexp_pix.sv
module colexp_pix
  import colexp_pkg::*;
#(
  parameter int STEP_W = 4
) (
  input  colexp_job_t       job_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              we_o,
  output logic [STEP_W-1:0] off_o,
  output logic [7:0]        data_o
);
  localparam int PIX_W = $clog2(PIX_N);

  logic [PIX_W-1:0] pix;
  logic [PIX_W-1:0] bit_sel;
  logic             hi_byte;
  logic             src_bit;

  always_comb begin
    pix     = job_i.wide ? step_i[PIX_W:1] : step_i[PIX_W-1:0];
    hi_byte = job_i.wide & step_i[0];
    bit_sel = PIX_W'(PIX_N - 1) - pix;
    src_bit = job_i.src[bit_sel];
    we_o    = job_i.mask[bit_sel] & (src_bit | job_i.opaque);
    off_o   = step_i;
    if (src_bit) data_o = hi_byte ? job_i.fg_hi : job_i.fg_lo;
    else         data_o = hi_byte ? job_i.bg_hi : job_i.bg_lo;
  end
endmodule

// File: rtl/colexp_write_unit.sv
module colexp_write_unit
  import colexp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [7:0]        src_byte_i,
  input  logic [7:0]        mask_i,
  input  logic              opaque_i,
  input  logic              wide_i,
  input  logic [7:0]        fg_lo_i,
  input  logic [7:0]        fg_hi_i,
  input  logic [7:0]        bg_lo_i,
  input  logic [7:0]        bg_hi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int STEP_W = $clog2(2 * PIX_N);

  colexp_job_t       job_q;
  logic [ADDR_W-1:0] base_q;
  logic              accept, run, fin, pix_we;
  logic [STEP_W-1:0] step, off;
  logic [7:0]        pix_data;

  colexp_ctrl #(.STEP_W(STEP_W)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i), .wide_i(job_q.wide),
    .accept_o(accept), .run_o(run), .fin_o(fin), .step_o(step)
  );

  colexp_pix #(.STEP_W(STEP_W)) pix_i (
    .job_i(job_q), .step_i(step), .we_o(pix_we), .off_o(off), .data_o(pix_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      job_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      job_q  <= '{src: src_byte_i, mask: mask_i, fg_lo: fg_lo_i, fg_hi: fg_hi_i,
                  bg_lo: bg_lo_i, bg_hi: bg_hi_i, opaque: opaque_i, wide: wide_i};
      base_q <= base_addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      done_o      <= fin;
      mem_we_o    <= run & pix_we;
      mem_addr_o  <= base_q + ADDR_W'(off);
      mem_wdata_o <= pix_data;
      if (accept)   busy_o <= 1'b1;
      else if (fin) busy_o <= 1'b0;
    end
  end

  assert_we_in_op_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !mem_we_o));
  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
  assert_addr_window_R1: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> ((mem_addr_o - base_q) < ADDR_W'(2 * PIX_N)));
endmodule

// File: tb/colexp_write_unit_tb.sv
module colexp_write_unit_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [7:0]    src = '0, mask = '0, fgl = '0, fgh = '0, bgl = '0, bgh = '0;
  logic          opaque = 1'b0, wide = 1'b0;
  logic          busy, done, we;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;

  int checks = 0, errors = 0;
  int wcount = 0, order_bad = 0, op_id = 0, seen_op = -1;
  int last_addr = 0;
  logic [7:0] mem [256];
  logic [7:0] expm [256];

  always #2.5 clk = ~clk;

  colexp_write_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .base_addr_i(base), .src_byte_i(src),
    .mask_i(mask), .opaque_i(opaque), .wide_i(wide), .fg_lo_i(fgl), .fg_hi_i(fgh),
    .bg_lo_i(bgl), .bg_hi_i(bgh), .busy_o(busy), .done_o(done), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata)
  );

  always @(posedge clk) begin
    if (we) begin
      mem[addr[7:0]] <= wdata;
      wcount <= wcount + 1;
      if (seen_op == op_id && int'(addr) <= last_addr) order_bad <= order_bad + 1;
      seen_op   <= op_id;
      last_addr <= int'(addr);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic run_op(input string req, input logic [AW-1:0] b, input logic [7:0] s,
                        input logic [7:0] m, input bit op, input bit wd, input bit restart);
    int n, w0, ew, bad;
    logic [7:0] c_fl, c_fh, c_bl, c_bh;
    c_fl = 8'h11 + s; c_fh = 8'hE2 ^ s; c_bl = 8'h3C + m; c_bh = 8'h96 ^ m;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'(i) ^ 8'hA5;
      expm[i] = 8'(i) ^ 8'hA5;
    end
    ew = 0;
    for (int p = 0; p < 8; p++) begin
      int a;
      a = int'(b) + p * (wd ? 2 : 1);
      if (m[7-p] && (s[7-p] || op)) begin
        expm[a] = s[7-p] ? c_fl : c_bl;
        ew++;
        if (wd) begin
          expm[a+1] = s[7-p] ? c_fh : c_bh;
          ew++;
        end
      end
    end
    op_id++;
    w0 = wcount;
    @(negedge clk);
    base = b; src = s; mask = m; opaque = op; wide = wd;
    fgl = c_fl; fgh = c_fh; bgl = c_bl; bgh = c_bh; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    // R9: scramble every operand after the strobe
    base = ~b; src = ~s; mask = ~m; opaque = ~op; wide = ~wd;
    fgl = ~c_fl; fgh = ~c_fh; bgl = ~c_bl; bgh = ~c_bh;
    chk(busy == 1'b1, {req, " R8 busy after start"}, int'(busy), 1);
    if (restart) start = 1'b1;
    n = 0;
    while (!done && n < 64) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk(n == (wd ? 17 : 9), {req, " R10 latency"}, n, wd ? 17 : 9);
    chk(busy == 1'b0, {req, " R8 busy low at done"}, int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(!busy && !done, {req, " R8 quiet after done"}, int'(busy || done), 0);
    chk(wcount - w0 == ew, {req, " write count"}, wcount - w0, ew);
    chk(order_bad == 0, {req, " R1 address order"}, order_bad, 0);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
    chk(bad == 0, {req, " memory image"}, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !we, "R11 reset state", int'({busy, done, we}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_op("R1 R2 R3 R6 narrow opaque", 16'd10, 8'hA5, 8'hFF, 1'b1, 1'b0, 1'b0);
    run_op("R4 narrow transparent", 16'd40, 8'h3C, 8'hFF, 1'b0, 1'b0, 1'b0);
    run_op("R5 mask low half", 16'd60, 8'hFF, 8'h0F, 1'b1, 1'b0, 1'b0);
    run_op("R5 R3 mask ends", 16'd80, 8'h00, 8'h81, 1'b1, 1'b0, 1'b0);
    run_op("R7 wide opaque", 16'd100, 8'hC3, 8'hFF, 1'b1, 1'b1, 1'b0);
    run_op("R7 R4 R5 wide transparent masked", 16'd140, 8'h5A, 8'hF0, 1'b0, 1'b1, 1'b0);
    run_op("R10 narrow none enabled", 16'd170, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0);
    run_op("R10 wide none enabled", 16'd180, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b0);
    run_op("R8 R9 restart ignored", 16'd200, 8'h96, 8'h7E, 1'b1, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule